// File: doc/BRIEF.md
# Type B Proximity Card Anticollision Controller

This block is the card-side controller for Type B contactless anticollision. Upstream logic decodes and CRC-checks each frame and hands over the payload bytes, the payload length and a CRC verdict in a single cycle. From these frames the block steers the card through five phases: idle, waiting for its slot, declared, active and halted. It draws a random slot for each probe and decides when the card must answer. Each answer is an ATQB, an ATTRIB acknowledgement, a halt acknowledgement or a deselect acknowledgement, and the block builds its bytes in a response buffer and pulses a request to the frame transmitter. The card's 32-bit serial identifier and its 32-bit application data arrive as static inputs.

Once the card is active, the block passes each data command addressed to its stored 4-bit card identifier to the downstream command processor. It does this by pulsing a forward strobe that carries a registered copy of the frame. Lengths count payload bytes only, without the two CRC bytes. Byte 0 is the first byte received and sits in bits [7:0] of each byte bus. A multi-byte value travels least significant byte first.

Top module: `pxb_anticoll`

## Requirements
- R1: After reset `phase` is 0 (idle), and `tx_req` and `fwd_valid` are low.
- R2: A probe is 3 bytes long with byte 0 = 0x05. Byte 1 (the family selector) must be 0x00 or 0x01. Byte 2 bit 3 = 1 marks the wake-up variant. Byte 2 bits [2:0] give the slot count N as 2^value, and only values 0..4 are legal. A probe that breaks any of these rules is ignored.
- R3: An accepted probe with N = 1 pulses `tx_req` on the next cycle with 11 bytes and moves `phase` to 2 (declared). The bytes are the serial identifier, then the application data, then 0x00, 0x00, 0x41.
- R4: For N > 1 the card draws a slot R in 1..N. If R = 1 it answers at once as in R3. Otherwise it enters `phase` 1 and answers exactly one slot marker, the one that selects R, with an ATQB.
- R5: A slot marker is 1 byte with a high nibble of 0xA. Only its low log2(N) bits are compared with R taken modulo N, so slot N is selected by a value of 0.
- R6: In `phase` 2 an ATTRIB of 9 to 14 bytes whose bytes 1..4 equal the serial identifier is accepted. The card stores byte 8 bits [3:0] as the card identifier (`card_cid`), replies with 1 byte {0x0, cid} and enters `phase` 3 (active). If the identifier does not match, the frame is ignored.
- R7: In `phase` 2 a halt command of 5 bytes (0x50 followed by the matching serial identifier) gets the 1-byte reply 0x00 and moves the card to `phase` 4 (halt). A halt command received in `phase` 3 is ignored.
- R8: In `phase` 4 a plain probe is ignored. Only a wake-up probe that is otherwise valid is answered.
- R9: In `phase` 3 a 10-byte frame whose byte 0 has low nibble equal to `card_cid` and high nibble other than 0xA is copied to `fwd_len`/`fwd_bytes`, and `fwd_valid` pulses for one cycle. A frame with a different identifier is dropped.
- R10: In `phase` 3 a 10-byte frame with byte 0 = {0xA, cid} gets the 2-byte reply {byte 0, 0x00} and moves the card to `phase` 4.
- R11: A frame with `rx_crc_ok` low changes neither the phase nor any output, whatever its content.
- R12: `tx_req` and `fwd_valid` are never high in the same cycle. When the ATQB length is presented, the phase is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| rx_crc_ok | input | 1 | CRC verdict for the present frame |
| rx_len | input | LEN_W | Payload length in bytes, CRC excluded |
| rx_bytes | input | RX_BYTES*8 | Payload, byte 0 in bits [7:0] |
| serial_id | input | 32 | Card serial identifier |
| app_data | input | 32 | Application data sent in the ATQB |
| tx_req | output | 1 | One-cycle request to transmit the response buffer |
| tx_len | output | TXL_W | Response length in bytes |
| tx_bytes | output | 88 | Response buffer, byte 0 in bits [7:0] |
| fwd_valid | output | 1 | One-cycle strobe: a data command is forwarded |
| fwd_len | output | LEN_W | Length of the forwarded frame |
| fwd_bytes | output | RX_BYTES*8 | Copy of the forwarded frame |
| card_cid | output | 4 | Stored card identifier |
| phase | output | 3 | 0 idle, 1 slot wait, 2 declared, 3 active, 4 halt |

## Verification
The bench first sends malformed probes: a wrong header, a wrong family selector, a reserved slot code and a wrong length. These separate probe validation from the acceptance path. For each slot count it then repeats probes at varying idle gaps so that different random slots come up. After each probe it scans every slot marker from 2 to N, setting an extra bit above the truncation width. Exactly one answer per probe shows that the slot draw and the truncated comparison are right. It then sends ATTRIB, halt, deselect and data commands with matching and mismatched identifiers in each phase, and replays valid frames with a bad CRC. These show which frames each phase accepts, ignores or forwards.

// File: rtl/pxb_anticoll_pkg.sv
package pxb_anticoll_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RSLOT  = 3'd1,
    PH_RDECL  = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_HALT   = 3'd4
  } phase_t;

  localparam logic [7:0] PROBE_HDR = 8'h05;
  localparam logic [7:0] HALT_HDR  = 8'h50;
  localparam logic [3:0] SLOT_TAG  = 4'hA;
  localparam logic [3:0] DESEL_OP  = 4'hA;
  localparam logic [7:0] PROTO_B0  = 8'h00;
  localparam logic [7:0] PROTO_B1  = 8'h00;
  localparam logic [7:0] PROTO_B2  = 8'h41;

  localparam int PROBE_LEN  = 3;
  localparam int SLOT_LEN   = 1;
  localparam int HALT_LEN   = 5;
  localparam int ATT_MIN    = 9;
  localparam int ATT_MAX    = 14;
  localparam int CMD_LEN    = 10;
  localparam int ATQB_BYTES = 11;
  localparam int MAX_NCODE  = 4;
endpackage

// File: rtl/pxb_lfsr16.sv
module pxb_lfsr16 #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] q
);
  logic fb;
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], fb};
  end

  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst) q != 16'h0);
endmodule

// File: rtl/pxb_frame_class.sv
module pxb_frame_class
  import pxb_anticoll_pkg::*;
#(
  parameter int RX_BYTES = 14,
  parameter int LEN_W    = $clog2(RX_BYTES + 1)
) (
  input  logic [RX_BYTES*8-1:0] rx_bytes,
  input  logic [LEN_W-1:0]      rx_len,
  input  logic [31:0]           serial_id,
  input  logic [3:0]            cid,
  output logic                  is_probe,
  output logic                  is_wake,
  output logic [2:0]            n_code,
  output logic                  is_slot,
  output logic [3:0]            slot_nib,
  output logic                  is_attrib,
  output logic [3:0]            attrib_cid,
  output logic                  is_halt,
  output logic                  is_desel,
  output logic                  is_dcmd
);
  localparam int ID_BYTES = 4;

  logic [7:0] b0, b1, b2, b8;
  logic [ID_BYTES-1:0] id_hit;
  logic id_match, len_att, cid_hit;

  assign b0 = rx_bytes[7:0];
  assign b1 = rx_bytes[15:8];
  assign b2 = rx_bytes[23:16];
  assign b8 = rx_bytes[71:64];

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
    assign id_hit[i] = (rx_bytes[8*(i+1) +: 8] == serial_id[8*i +: 8]);
  end
  assign id_match = &id_hit;

  assign len_att = (int'(rx_len) >= ATT_MIN) && (int'(rx_len) <= ATT_MAX);
  assign cid_hit = (b0[3:0] == cid) && (int'(rx_len) == CMD_LEN);

  assign n_code     = b2[2:0];
  assign is_wake    = b2[3];
  assign is_probe   = (int'(rx_len) == PROBE_LEN) && (b0 == PROBE_HDR) &&
                      (b1[7:1] == 7'd0) && (int'(n_code) <= MAX_NCODE);
  assign is_slot    = (int'(rx_len) == SLOT_LEN) && (b0[7:4] == SLOT_TAG);
  assign slot_nib   = b0[3:0];
  assign is_attrib  = len_att && id_match;
  assign attrib_cid = b8[3:0];
  assign is_halt    = (int'(rx_len) == HALT_LEN) && (b0 == HALT_HDR) && id_match;
  assign is_desel   = cid_hit && (b0[7:4] == DESEL_OP);
  assign is_dcmd    = cid_hit && (b0[7:4] != DESEL_OP);
endmodule

// File: rtl/pxb_anticoll.sv
module pxb_anticoll
  import pxb_anticoll_pkg::*;
#(
  parameter int          RX_BYTES = 14,
  parameter logic [15:0] SEED     = 16'hACE1,
  parameter int          LEN_W    = $clog2(RX_BYTES + 1),
  parameter int          TXL_W    = $clog2(ATQB_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic                  rx_crc_ok,
  input  logic [LEN_W-1:0]      rx_len,
  input  logic [RX_BYTES*8-1:0] rx_bytes,
  input  logic [31:0]           serial_id,
  input  logic [31:0]           app_data,
  output logic                  tx_req,
  output logic [TXL_W-1:0]      tx_len,
  output logic [ATQB_BYTES*8-1:0] tx_bytes,
  output logic                  fwd_valid,
  output logic [LEN_W-1:0]      fwd_len,
  output logic [RX_BYTES*8-1:0] fwd_bytes,
  output logic [3:0]            card_cid,
  output logic [2:0]            phase
);
  phase_t     st;
  logic [15:0] rnd;
  logic [4:0]  slot_r;
  logic [3:0]  mask_r;

  logic       c_probe, c_wake, c_slot, c_attrib, c_halt, c_desel, c_dcmd;
  logic [2:0] c_ncode;
  logic [3:0] c_nib, c_acid, d_mask;
  logic [4:0] d_slot;
  logic       ok, take_probe, slot_hit;

  pxb_lfsr16 #(.SEED(SEED)) u_rng (.clk(clk), .rst(rst), .q(rnd));

  pxb_frame_class #(.RX_BYTES(RX_BYTES), .LEN_W(LEN_W)) u_cls (
    .rx_bytes(rx_bytes), .rx_len(rx_len), .serial_id(serial_id), .cid(card_cid),
    .is_probe(c_probe), .is_wake(c_wake), .n_code(c_ncode),
    .is_slot(c_slot), .slot_nib(c_nib), .is_attrib(c_attrib), .attrib_cid(c_acid),
    .is_halt(c_halt), .is_desel(c_desel), .is_dcmd(c_dcmd)
  );

  always_comb begin
    d_mask = 4'((5'd1 << c_ncode) - 5'd1);
    d_slot = {1'b0, rnd[3:0] & d_mask} + 5'd1;
    ok = rx_valid && rx_crc_ok;
    take_probe = ok && c_probe && (st != PH_ACTIVE) && ((st != PH_HALT) || c_wake);
    slot_hit = ok && c_slot && (st == PH_RSLOT) &&
               ((c_nib & mask_r) == (slot_r[3:0] & mask_r));
  end

  assign phase = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      slot_r    <= 5'd1;
      mask_r    <= 4'd0;
      card_cid  <= 4'd0;
      tx_req    <= 1'b0;
      tx_len    <= '0;
      tx_bytes  <= '0;
      fwd_valid <= 1'b0;
      fwd_len   <= '0;
      fwd_bytes <= '0;
    end else begin
      tx_req    <= 1'b0;
      fwd_valid <= 1'b0;
      if (take_probe) begin
        slot_r <= d_slot;
        mask_r <= d_mask;
        if (d_slot == 5'd1) begin
          st       <= PH_RDECL;
          tx_req   <= 1'b1;
          tx_len   <= TXL_W'(ATQB_BYTES);
          tx_bytes <= {PROTO_B2, PROTO_B1, PROTO_B0, app_data, serial_id};
        end else begin
          st <= PH_RSLOT;
        end
      end else if (slot_hit) begin
        st       <= PH_RDECL;
        tx_req   <= 1'b1;
        tx_len   <= TXL_W'(ATQB_BYTES);
        tx_bytes <= {PROTO_B2, PROTO_B1, PROTO_B0, app_data, serial_id};
      end else if (ok && c_attrib && st == PH_RDECL) begin
        st            <= PH_ACTIVE;
        card_cid      <= c_acid;
        tx_req        <= 1'b1;
        tx_len        <= TXL_W'(1);
        tx_bytes      <= '0;
        tx_bytes[7:0] <= {4'h0, c_acid};
      end else if (ok && c_halt && st == PH_RDECL) begin
        st       <= PH_HALT;
        tx_req   <= 1'b1;
        tx_len   <= TXL_W'(1);
        tx_bytes <= '0;
      end else if (ok && c_desel && st == PH_ACTIVE) begin
        st             <= PH_HALT;
        tx_req         <= 1'b1;
        tx_len         <= TXL_W'(2);
        tx_bytes       <= '0;
        tx_bytes[15:0] <= {8'h00, rx_bytes[7:0]};
      end else if (ok && c_dcmd && st == PH_ACTIVE) begin
        fwd_valid <= 1'b1;
        fwd_len   <= rx_len;
        fwd_bytes <= rx_bytes;
      end
    end
  end

  // R12: the two output strobes are exclusive
  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(tx_req && fwd_valid));
  // R12 / R3: a full ATQB always leaves the card declared
  a_r3_atqb_declared: assert property (@(posedge clk) disable iff (rst)
    (tx_req && int'(tx_len) == ATQB_BYTES) |-> (phase == 3'd2));
  // R9: forwarding happens only while active
  a_r9_fwd_active: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (phase == 3'd3));
  // R11: a frame with a bad CRC leaves the phase alone
  a_r11_crc_ignored: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_crc_ok) |=> $stable(phase));
  // R6: entering the active phase always comes with a 1-byte reply
  a_r6_active_entry: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && $past(phase) != 3'd3) |-> (tx_req && int'(tx_len) == 1));
  // R7 / R10: entering halt always comes with an acknowledgement
  a_r7_halt_ack: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4 && $past(phase) != 3'd4) |-> tx_req);
endmodule

// File: tb/pxb_anticoll_test.sv
module pxb_anticoll_test;
  localparam int CLK_PERIOD = 10;
  localparam int RXB = 14;
  localparam int LW  = 4;
  localparam int TW  = 4;
  localparam logic [31:0] SID = 32'h8C3B_5A17;
  localparam logic [31:0] APP = 32'h0F1E_2D3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_crc_ok = 1'b0;
  logic [LW-1:0] rx_len = '0;
  logic [RXB*8-1:0] rx_bytes = '0;
  logic tx_req, fwd_valid;
  logic [TW-1:0] tx_len;
  logic [87:0] tx_bytes;
  logic [LW-1:0] fwd_len;
  logic [RXB*8-1:0] fwd_bytes;
  logic [3:0] card_cid;
  logic [2:0] phase;

  int errors = 0, checks = 0;
  logic [7:0] fb [0:RXB-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  pxb_anticoll uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok),
    .rx_len(rx_len), .rx_bytes(rx_bytes), .serial_id(SID), .app_data(APP),
    .tx_req(tx_req), .tx_len(tx_len), .tx_bytes(tx_bytes),
    .fwd_valid(fwd_valid), .fwd_len(fwd_len), .fwd_bytes(fwd_bytes),
    .card_cid(card_cid), .phase(phase)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < RXB; i++) fb[i] = 8'h00;
  endtask

  // drive one frame on a negedge, sample outputs at the next negedge
  task automatic send(input int len, input logic crc);
    @(negedge clk);
    for (int i = 0; i < RXB; i++) rx_bytes[8*i +: 8] = fb[i];
    rx_len = LW'(len);
    rx_crc_ok = crc;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic probe(input logic [7:0] afi, input logic wake, input logic [2:0] nc, input logic crc);
    clr();
    fb[0] = 8'h05; fb[1] = afi; fb[2] = {4'h0, wake, nc};
    send(3, crc);
  endtask

  task automatic chk_atqb(input string tag);
    chk({tag, " req"}, 64'(tx_req), 64'd1);
    chk({tag, " len"}, 64'(tx_len), 64'd11);
    chk({tag, " body"}, 64'(tx_bytes[63:0]), {APP, SID});
    chk({tag, " proto"}, 64'(tx_bytes[87:64]), 64'h41_00_00);
    chk({tag, " phase"}, 64'(phase), 64'd2);
  endtask

  task automatic attrib(input logic [31:0] id, input logic [3:0] cid, input int len);
    clr();
    fb[0] = 8'h1D;
    for (int i = 0; i < 4; i++) fb[1+i] = id[8*i +: 8];
    fb[8] = {4'h5, cid};
    send(len, 1'b1);
  endtask

  task automatic halt_cmd(input logic [31:0] id);
    clr();
    fb[0] = 8'h50;
    for (int i = 0; i < 4; i++) fb[1+i] = id[8*i +: 8];
    send(5, 1'b1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 phase", 64'(phase), 64'd0);
    chk("R1 tx_req", 64'(tx_req), 64'd0);
    chk("R1 fwd_valid", 64'(fwd_valid), 64'd0);
  endtask

  task automatic t_bad_probes();
    clr(); fb[0] = 8'h06; fb[1] = 8'h00; fb[2] = 8'h00; send(3, 1'b1);
    chk("R2 bad header", 64'({tx_req, phase}), 64'd0);
    probe(8'h02, 1'b0, 3'd0, 1'b1);
    chk("R2 bad family", 64'({tx_req, phase}), 64'd0);
    probe(8'h00, 1'b0, 3'd5, 1'b1);
    chk("R2 reserved code", 64'({tx_req, phase}), 64'd0);
    clr(); fb[0] = 8'h05; send(4, 1'b1);
    chk("R2 bad length", 64'({tx_req, phase}), 64'd0);
    probe(8'h00, 1'b0, 3'd0, 1'b0);
    chk("R11 probe bad crc", 64'({tx_req, phase}), 64'd0);
  endtask

  task automatic t_select_path();
    probe(8'h00, 1'b0, 3'd0, 1'b1);
    chk_atqb("R3 n1");
    attrib(SID ^ 32'h100, 4'h9, 9);
    chk("R6 wrong id", 64'({tx_req, phase}), 64'd2);
    attrib(SID, 4'h9, 9);
    chk("R6 reply req", 64'(tx_req), 64'd1);
    chk("R6 reply len", 64'(tx_len), 64'd1);
    chk("R6 reply byte", 64'(tx_bytes[7:0]), 64'h09);
    chk("R6 phase", 64'(phase), 64'd3);
    chk("R6 cid", 64'(card_cid), 64'h9);
  endtask

  task automatic t_active();
    halt_cmd(SID);
    chk("R7 halt in active", 64'({tx_req, phase}), 64'd3);
    probe(8'h00, 1'b1, 3'd0, 1'b1);
    chk("R9 probe in active", 64'({tx_req, phase}), 64'd3);
    clr(); fb[0] = 8'h49; fb[1] = 8'h07; fb[9] = 8'hC4; send(10, 1'b1);
    chk("R9 fwd strobe", 64'(fwd_valid), 64'd1);
    chk("R9 fwd len", 64'(fwd_len), 64'd10);
    chk("R9 fwd bytes", 64'(fwd_bytes[79:72]), 64'hC4);
    chk("R9 fwd head", 64'(fwd_bytes[15:0]), 64'h0749);
    chk("R12 no tx on fwd", 64'(tx_req), 64'd0);
    clr(); fb[0] = 8'h45; send(10, 1'b1);
    chk("R9 other cid", 64'(fwd_valid), 64'd0);
    clr(); fb[0] = 8'hA9; send(10, 1'b0);
    chk("R11 deselect bad crc", 64'({tx_req, fwd_valid, phase}), 64'd3);
    clr(); fb[0] = 8'hA9; send(10, 1'b1);
    chk("R10 reply req", 64'(tx_req), 64'd1);
    chk("R10 reply", 64'({tx_len, tx_bytes[15:0]}), {4'd2, 16'h00A9});
    chk("R10 phase", 64'(phase), 64'd4);
  endtask

  task automatic t_halt();
    probe(8'h00, 1'b0, 3'd0, 1'b1);
    chk("R8 plain probe in halt", 64'({tx_req, phase}), 64'd4);
    probe(8'h02, 1'b1, 3'd0, 1'b1);
    chk("R8 wake bad family", 64'({tx_req, phase}), 64'd4);
    probe(8'h01, 1'b1, 3'd0, 1'b1);
    chk_atqb("R8 wake");
    halt_cmd(SID ^ 32'h1);
    chk("R7 halt wrong id", 64'({tx_req, phase}), 64'd2);
    halt_cmd(SID);
    chk("R7 halt reply", 64'({tx_req, tx_len, tx_bytes[7:0]}), {1'b1, 4'd1, 8'h00});
    chk("R7 phase", 64'(phase), 64'd4);
  endtask

  task automatic t_slots();
    int marker_hits = 0;
    for (int nc = 1; nc <= 4; nc++) begin
      for (int t = 0; t < 6; t++) begin
        int n = 1 << nc;
        int answers = 0;
        repeat (t * 3 + nc) @(negedge clk);
        probe(8'h01, 1'b1, 3'(nc), 1'b1);
        if (tx_req) answers++;
        else chk("R4 waiting phase", 64'(phase), 64'd1);
        for (int s = 2; s <= n; s++) begin
          clr();
          fb[0] = {4'hA, 4'((s | n) & 15)};
          send(1, 1'b1);
          if (tx_req) begin
            answers++;
            marker_hits++;
            chk_atqb("R5 marker atqb");
          end
        end
        chk("R4 exactly one answer", 64'(answers), 64'd1);
      end
    end
    checks++;
    if (marker_hits == 0) begin
      errors++;
      $display("FAIL R5 actual=0 expected=nonzero marker answers");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bad_probes();
    t_select_path();
    t_active();
    t_halt();
    t_slots();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule